// File: doc/BRIEF.md
# Double-to-Single Precision Rounder

This block narrows a 64-bit binary floating-point operand to the nearest single-precision value. It then widens that value back into 64-bit double encoding, so a register file that holds only doubles can store the narrowed number with no second format. Rounding follows a 2-bit mode input that can change on every operation. Special operands follow fixed rules. Signalling NaNs are quieted. Finite values that are too large saturate to infinity or to the largest finite single. Values that are too small become single denormals or zero.

Each operation comes with a valid strobe, and one cycle later the result comes back with a valid flag. Three exception pulses come with it: signalling-NaN invalid, inexact and overflow. A 4-bit class code reports the category and sign of the produced single value. The surrounding unit accumulates the pulses into its own status register and decides whether to trap. The class code keeps its value between operations.

Top module: `d2s_rounder`

## Requirements
- R1: The result, the exception pulses and `out_valid` appear on the clock edge after the one that samples `in_valid`. Exception pulses are high only in a cycle where `out_valid` is high.
- R2: Rounding mode `in_rmode`: 00 round to nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: Every result is the single-precision value widened exactly to double encoding, so the low 29 fraction bits are zero. An operand that is already representable as a single returns unchanged and raises no flag.
- R4: A signalling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear) raises `out_snan_inv`. The result keeps the sign, sets fraction bit 51 and keeps only fraction bits 50..29 as payload.
- R5: A quiet NaN (fraction bit 51 set) returns with its payload cut to fraction bits 51..29 and raises no exception.
- R6: `out_inexact` is raised exactly when the operand is finite, the result is finite and the result differs from the operand.
- R7: A finite operand whose rounded value exceeds the single range raises `out_overflow`. The result is infinity in mode 00. In mode 01 it is the largest finite single. In mode 10 it is +infinity for a positive operand and the largest negative finite single for a negative one. Mode 11 mirrors mode 10. A value that rounds down to the largest finite single does not overflow.
- R8: Values below the single normal range, including double denormals, round to single denormals, to zero or up to the smallest normal single, following the mode.
- R9: Infinities and signed zeros pass through unchanged with no exception.
- R10: `out_class` takes a new value with each result: 0 +zero, 1 -zero, 2 +denormal, 3 -denormal, 4 +normal, 5 -normal, 6 +infinity, 7 -infinity, 8 NaN. It holds that value while `out_valid` is low. Inputs presented with `in_valid` low have no effect.
- R11: While `rst_n` is low, `out_valid`, the pulses, `out_result` and `out_class` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Double-precision operand |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Rounded single value in double encoding |
| out_snan_inv | output | 1 | Signalling-NaN invalid pulse |
| out_inexact | output | 1 | Inexact pulse |
| out_overflow | output | 1 | Overflow pulse |
| out_class | output | 4 | Class and sign of the last result |

## Verification
The hardest cases to reach sit on the carries between ranges. One is a tie at the top of the denormal range that rounds up into the smallest normal. Another is a tie on the largest finite single that overflows in one mode but not in another. The third is a double denormal that must collapse to zero or to the smallest single denormal. Plain random operands almost never hit these. The stimulus therefore builds exact operands at each boundary (halfway points, exact midpoints with odd and even last bits, the smallest double denormal) and runs each of them through several rounding modes back to back.

// File: rtl/d2s_pkg.sv
package d2s_pkg;

   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_UP   = 2'b10,
      RM_DOWN = 2'b11
   } rmode_t;

   typedef enum logic [3:0] {
      CL_PZERO = 4'd0,
      CL_NZERO = 4'd1,
      CL_PSUB  = 4'd2,
      CL_NSUB  = 4'd3,
      CL_PNORM = 4'd4,
      CL_NNORM = 4'd5,
      CL_PINF  = 4'd6,
      CL_NINF  = 4'd7,
      CL_NAN   = 4'd8
   } fclass_t;

endpackage

// File: rtl/d2s_round.sv
// Narrows a finite nonzero wide operand to the narrow format.
module d2s_round #(
   parameter int EI = 11,
   parameter int FI = 52,
   parameter int EO = 8,
   parameter int FO = 23
) (
   input  logic             sign,
   input  logic [EI-1:0]    exp_i,
   input  logic [FI-1:0]    frac_i,
   input  d2s_pkg::rmode_t  rmode,
   output logic [EO-1:0]    exp_o,
   output logic [FO-1:0]    frac_o,
   output logic             ovf
);
   import d2s_pkg::*;

   localparam int BI     = (1 << (EI-1)) - 1;
   localparam int BO     = (1 << (EO-1)) - 1;
   localparam int REBIAS = BI - BO;
   localparam int DROP   = FI - FO;
   localparam int MW     = FI + 1;
   localparam int SH_MAX = MW + 2;
   localparam int SHW    = $clog2(SH_MAX + 1);
   localparam int EMAX   = (1 << EO) - 1;

   logic [MW-1:0]  mant;
   logic [SHW-1:0] sh;
   logic           denorm;
   int             es;
   int             ex_r;
   logic [FO:0]    kept;
   logic           guard;
   logic           sticky;
   logic           inc;
   logic           to_inf;
   logic [FO+1:0]  sum;

   always_comb begin
      mant = {(exp_i != '0), frac_i};
      if (exp_i == '0) es = 1 - REBIAS;
      else             es = int'(exp_i) - REBIAS;
      denorm = (es < 1);

      // total right shift: fraction narrowing plus denormal alignment
      if (!denorm)                     sh = SHW'(DROP);
      else if (DROP + 1 - es > SH_MAX) sh = SHW'(SH_MAX);
      else                             sh = SHW'(DROP + 1 - es);

      kept   = (FO+1)'(mant >> sh);
      guard  = |(mant & (MW'(1) << (sh - 1'b1)));
      sticky = |(mant & ~({MW{1'b1}} << (sh - 1'b1)));

      unique case (rmode)
         RM_NEAR: inc = guard & (sticky | kept[0]);
         RM_ZERO: inc = 1'b0;
         RM_UP:   inc = ~sign & (guard | sticky);
         RM_DOWN: inc =  sign & (guard | sticky);
         default: inc = 1'b0;
      endcase

      sum = {1'b0, kept} + {{(FO+1){1'b0}}, inc};

      if (denorm) ex_r = sum[FO] ? 1 : 0;
      else        ex_r = es + int'(sum[FO+1]);

      ovf    = (ex_r >= EMAX);
      to_inf = (rmode == RM_NEAR) ||
               ((rmode == RM_UP)   && !sign) ||
               ((rmode == RM_DOWN) &&  sign);

      if (ovf) begin
         exp_o  = to_inf ? {EO{1'b1}} : EO'(EMAX - 1);
         frac_o = to_inf ? {FO{1'b0}} : {FO{1'b1}};
      end else begin
         exp_o  = EO'(ex_r);
         frac_o = sum[FO-1:0];
      end
   end

endmodule

// File: rtl/d2s_widen.sv
// Re-expresses a narrow-format value exactly in the wide format.
module d2s_widen #(
   parameter int EI = 11,
   parameter int FI = 52,
   parameter int EO = 8,
   parameter int FO = 23
) (
   input  logic            sign,
   input  logic [EO-1:0]   exp_s,
   input  logic [FO-1:0]   frac_s,
   output logic [EI+FI:0]  dbl
);
   localparam int BI     = (1 << (EI-1)) - 1;
   localparam int BO     = (1 << (EO-1)) - 1;
   localparam int REBIAS = BI - BO;
   localparam int DROP   = FI - FO;

   int          msb;
   logic [FO-1:0] norm;

   always_comb begin
      msb = 0;
      for (int i = 0; i < FO; i++) begin
         if (frac_s[i]) msb = i;
      end
      // leading one moves past the top bit and drops out
      norm = frac_s << (FO - msb);

      if (exp_s == {EO{1'b1}}) begin
         dbl = {sign, {EI{1'b1}}, frac_s, {DROP{1'b0}}};
      end else if (exp_s == '0) begin
         if (frac_s == '0)
            dbl = {sign, {(EI+FI){1'b0}}};
         else
            dbl = {sign, EI'(msb + 1 - BO - FO + BI), norm, {DROP{1'b0}}};
      end else begin
         dbl = {sign, EI'(int'(exp_s) + REBIAS), frac_s, {DROP{1'b0}}};
      end
   end

endmodule

// File: rtl/d2s_classify.sv
module d2s_classify #(
   parameter int EO = 8,
   parameter int FO = 23
) (
   input  logic              sign,
   input  logic [EO-1:0]     exp_s,
   input  logic [FO-1:0]     frac_s,
   output d2s_pkg::fclass_t  cls
);
   import d2s_pkg::*;

   always_comb begin
      if (exp_s == {EO{1'b1}}) begin
         if (frac_s != '0) cls = CL_NAN;
         else              cls = sign ? CL_NINF : CL_PINF;
      end else if (exp_s == '0) begin
         if (frac_s == '0) cls = sign ? CL_NZERO : CL_PZERO;
         else              cls = sign ? CL_NSUB  : CL_PSUB;
      end else begin
         cls = sign ? CL_NNORM : CL_PNORM;
      end
   end

endmodule

// File: rtl/d2s_rounder.sv
module d2s_rounder #(
   parameter int DEXP_W  = 11,
   parameter int DFRAC_W = 52,
   parameter int SEXP_W  = 8,
   parameter int SFRAC_W = 23,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [DEXP_W+DFRAC_W:0]       in_op,
   input  logic [1:0]                    in_rmode,
   output logic                          out_valid,
   output logic [DEXP_W+DFRAC_W:0]       out_result,
   output logic                          out_snan_inv,
   output logic                          out_inexact,
   output logic                          out_overflow,
   output logic [3:0]                    out_class
);
   import d2s_pkg::*;

   localparam int DW = 1 + DEXP_W + DFRAC_W;

   if (SFRAC_W + 1 >= DFRAC_W) begin : g_bad_frac
      $error("narrow fraction must be at least two bits shorter than the wide one");
   end
   if (SEXP_W >= DEXP_W) begin : g_bad_exp
      $error("narrow exponent must be shorter than the wide one");
   end
   if (SFRAC_W < 2) begin : g_bad_small
      $error("narrow fraction too short to carry a NaN payload");
   end

   logic               op_sign;
   logic [DEXP_W-1:0]  op_exp;
   logic [DFRAC_W-1:0] op_frac;
   logic               op_nan, op_inf, op_zero, op_finite, op_snan;

   assign {op_sign, op_exp, op_frac} = in_op;
   assign op_nan    = (op_exp == {DEXP_W{1'b1}}) && (op_frac != '0);
   assign op_inf    = (op_exp == {DEXP_W{1'b1}}) && (op_frac == '0);
   assign op_zero   = (op_exp == '0) && (op_frac == '0);
   assign op_finite = (op_exp != {DEXP_W{1'b1}});
   assign op_snan   = op_nan && !op_frac[DFRAC_W-1];

   logic [SEXP_W-1:0]  r_exp;
   logic [SFRAC_W-1:0] r_frac;
   logic               r_ovf;

   d2s_round #(
      .EI(DEXP_W), .FI(DFRAC_W), .EO(SEXP_W), .FO(SFRAC_W)
   ) i_round (
      .sign   (op_sign),
      .exp_i  (op_exp),
      .frac_i (op_frac),
      .rmode  (rmode_t'(in_rmode)),
      .exp_o  (r_exp),
      .frac_o (r_frac),
      .ovf    (r_ovf)
   );

   logic [SEXP_W-1:0]  s_exp;
   logic [SFRAC_W-1:0] s_frac;

   always_comb begin
      if (op_nan) begin
         s_exp  = {SEXP_W{1'b1}};
         s_frac = {1'b1, op_frac[DFRAC_W-2 -: SFRAC_W-1]};
      end else if (op_inf) begin
         s_exp  = {SEXP_W{1'b1}};
         s_frac = '0;
      end else if (op_zero) begin
         s_exp  = '0;
         s_frac = '0;
      end else begin
         s_exp  = r_exp;
         s_frac = r_frac;
      end
   end

   logic [DW-1:0] res_dbl;
   fclass_t       res_cls;

   d2s_widen #(
      .EI(DEXP_W), .FI(DFRAC_W), .EO(SEXP_W), .FO(SFRAC_W)
   ) i_widen (
      .sign   (op_sign),
      .exp_s  (s_exp),
      .frac_s (s_frac),
      .dbl    (res_dbl)
   );

   d2s_classify #(
      .EO(SEXP_W), .FO(SFRAC_W)
   ) i_classify (
      .sign   (op_sign),
      .exp_s  (s_exp),
      .frac_s (s_frac),
      .cls    (res_cls)
   );

   logic flag_snan, flag_inx, flag_ovf;
   assign flag_snan = in_valid && op_snan;
   assign flag_ovf  = in_valid && op_finite && !op_zero && r_ovf;
   assign flag_inx  = in_valid && op_finite && (s_exp != {SEXP_W{1'b1}}) &&
                      (res_dbl != in_op);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_snan_inv <= 1'b0;
            out_inexact  <= 1'b0;
            out_overflow <= 1'b0;
            out_class    <= CL_PZERO;
         end else begin
            out_valid    <= in_valid;
            out_snan_inv <= flag_snan;
            out_inexact  <= flag_inx;
            out_overflow <= flag_ovf;
            if (in_valid) begin
               out_result <= res_dbl;
               out_class  <= res_cls;
            end
         end
      end
   end else begin : g_comb
      always_comb begin
         out_valid    = in_valid;
         out_result   = res_dbl;
         out_snan_inv = flag_snan;
         out_inexact  = flag_inx;
         out_overflow = flag_ovf;
         out_class    = res_cls;
      end
   end

endmodule

// File: rtl/d2s_rounder_chk.sv
module d2s_rounder_chk #(
   parameter int DEXP_W  = 11,
   parameter int DFRAC_W = 52,
   parameter int SEXP_W  = 8,
   parameter int SFRAC_W = 23,
   parameter bit REG_OUT = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      out_valid,
   input logic [DEXP_W+DFRAC_W:0]   out_result,
   input logic                      out_snan_inv,
   input logic                      out_inexact,
   input logic                      out_overflow,
   input logic [3:0]                out_class
);
   localparam int DW     = 1 + DEXP_W + DFRAC_W;
   localparam int DROP   = DFRAC_W - SFRAC_W;
   localparam int REBIAS = ((1 << (DEXP_W-1)) - 1) - ((1 << (SEXP_W-1)) - 1);
   localparam logic [DW-2:0] MAG_INF = {{DEXP_W{1'b1}}, {DFRAC_W{1'b0}}};
   localparam logic [DW-2:0] MAG_MAX = {DEXP_W'(((1 << SEXP_W) - 2) + REBIAS),
                                        {SFRAC_W{1'b1}}, {DROP{1'b0}}};

   if (REG_OUT) begin : g_seq
      // R1
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      // R1
      idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      // R10
      class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> $stable(out_class));
   end

   // R1
   pulse_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_snan_inv || out_inexact || out_overflow) |-> out_valid);
   // R3
   widened_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_result[DROP-1:0] == '0));
   // R4
   quieted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_snan_inv |-> (out_result[DW-2 -: DEXP_W] == {DEXP_W{1'b1}} &&
                        out_result[DFRAC_W-1]));
   // R6
   inexact_finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_inexact |-> (out_class < 4'd6));
   // R7
   overflow_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> (out_result[DW-2:0] == MAG_INF ||
                        out_result[DW-2:0] == MAG_MAX));
   // R10
   class_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_class < 4'd8) |-> (out_result[DW-1] == out_class[0]));

endmodule

bind d2s_rounder d2s_rounder_chk #(
   .DEXP_W(DEXP_W), .DFRAC_W(DFRAC_W), .SEXP_W(SEXP_W),
   .SFRAC_W(SFRAC_W), .REG_OUT(REG_OUT)
) i_d2s_rounder_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .out_valid    (out_valid),
   .out_result   (out_result),
   .out_snan_inv (out_snan_inv),
   .out_inexact  (out_inexact),
   .out_overflow (out_overflow),
   .out_class    (out_class)
);

// File: tb/test_d2s_rounder.sv
module test_d2s_rounder;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_op = '0;
   logic [1:0]  in_rmode = '0;
   logic        out_valid;
   logic [63:0] out_result;
   logic        out_snan_inv, out_inexact, out_overflow;
   logic [3:0]  out_class;

   always #(CLK_PERIOD/2) clk = ~clk;

   d2s_rounder i_d2s_rounder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_rmode(in_rmode), .out_valid(out_valid), .out_result(out_result),
      .out_snan_inv(out_snan_inv), .out_inexact(out_inexact),
      .out_overflow(out_overflow), .out_class(out_class)
   );

   typedef struct {
      logic [63:0] res;
      logic        sn, ix, ov;
      logic [3:0]  cls;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   int          checks = 0;
   int          fails  = 0;
   logic [3:0]  last_cls = 4'd0;

   localparam logic [1:0] RN = 2'b00, RZ = 2'b01, RU = 2'b10, RD = 2'b11;

   task automatic check(bit ok, string tag, string what,
                        logic [63:0] act, logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic send(logic [63:0] op, logic [1:0] rm, logic [63:0] res,
                       bit sn, bit ix, bit ov, logic [3:0] cls, string tag);
      item_t it;
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = op;
      in_rmode = rm;
      it.res = res; it.sn = sn; it.ix = ix; it.ov = ov; it.cls = cls; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic idle(int n, logic [63:0] junk);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_op    = junk;
         in_rmode = RU;
      end
   endtask

   // monitor: compares every produced result against the scoreboard
   always @(negedge clk) begin
      item_t e;
      if (rst_n) begin
         if (out_valid) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R1", "valid without request", 64'd1, 64'd0);
            end else begin
               e = sb_q.pop_front();
               check(out_result == e.res, e.tag, "result", out_result, e.res);
               check(out_snan_inv == e.sn, e.tag, "snan", 64'(out_snan_inv), 64'(e.sn));
               check(out_inexact == e.ix, e.tag, "inexact", 64'(out_inexact), 64'(e.ix));
               check(out_overflow == e.ov, e.tag, "overflow", 64'(out_overflow), 64'(e.ov));
               check(out_class == e.cls, e.tag, "class", 64'(out_class), 64'(e.cls));
               last_cls = e.cls;
            end
         end else begin
            check(!(out_snan_inv || out_inexact || out_overflow), "R1",
                  "pulse without valid",
                  64'({out_snan_inv, out_inexact, out_overflow}), 64'd0);
            // R10 class held between results
            check(out_class == last_cls, "R10", "class hold", 64'(out_class), 64'(last_cls));
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(out_valid == 1'b0 && out_result == '0 && out_class == 4'd0 &&
            !out_snan_inv && !out_inexact && !out_overflow,
            "R11", "reset state", out_result, 64'd0);
      rst_n = 1'b1;
      idle(2, 64'd0);

      // R3 exact values
      send(64'h3FF0000000000000, RN, 64'h3FF0000000000000, 0, 0, 0, 4'd4, "R3");
      send(64'h3FB99999A0000000, RN, 64'h3FB99999A0000000, 0, 0, 0, 4'd4, "R3");
      // R2 tie to even and directed modes
      send(64'h3FF0000010000000, RN, 64'h3FF0000000000000, 0, 1, 0, 4'd4, "R2");
      send(64'h3FF0000010000000, RZ, 64'h3FF0000000000000, 0, 1, 0, 4'd4, "R2");
      send(64'h3FF0000010000000, RU, 64'h3FF0000020000000, 0, 1, 0, 4'd4, "R2");
      send(64'h3FF0000010000000, RD, 64'h3FF0000000000000, 0, 1, 0, 4'd4, "R2");
      send(64'h3FF0000030000000, RN, 64'h3FF0000040000000, 0, 1, 0, 4'd4, "R2");
      send(64'hBFF0000010000001, RN, 64'hBFF0000020000000, 0, 1, 0, 4'd5, "R2");
      send(64'hBFF0000010000001, RZ, 64'hBFF0000000000000, 0, 1, 0, 4'd5, "R2");
      send(64'hBFF0000010000001, RU, 64'hBFF0000000000000, 0, 1, 0, 4'd5, "R2");
      send(64'hBFF0000010000001, RD, 64'hBFF0000020000000, 0, 1, 0, 4'd5, "R6");
      // R4 signalling NaNs
      send(64'h7FF0000000000001, RN, 64'h7FF8000000000000, 1, 0, 0, 4'd8, "R4");
      send(64'hFFF4000000000000, RZ, 64'hFFFC000000000000, 1, 0, 0, 4'd8, "R4");
      // R5 quiet NaNs
      send(64'h7FFABCDEF0000000, RU, 64'h7FFABCDEE0000000, 0, 0, 0, 4'd8, "R5");
      send(64'h7FF8000000000123, RN, 64'h7FF8000000000000, 0, 0, 0, 4'd8, "R5");
      idle(2, 64'h0);
      // R9 infinities and zeros
      send(64'h7FF0000000000000, RN, 64'h7FF0000000000000, 0, 0, 0, 4'd6, "R9");
      send(64'hFFF0000000000000, RD, 64'hFFF0000000000000, 0, 0, 0, 4'd7, "R9");
      send(64'h0000000000000000, RU, 64'h0000000000000000, 0, 0, 0, 4'd0, "R9");
      send(64'h8000000000000000, RD, 64'h8000000000000000, 0, 0, 0, 4'd1, "R9");
      // R7 overflow per mode
      send(64'h7FE0000000000000, RN, 64'h7FF0000000000000, 0, 0, 1, 4'd6, "R7");
      send(64'h7FE0000000000000, RZ, 64'h47EFFFFFE0000000, 0, 1, 1, 4'd4, "R7");
      send(64'hFFE0000000000000, RU, 64'hC7EFFFFFE0000000, 0, 1, 1, 4'd5, "R7");
      send(64'hFFE0000000000000, RD, 64'hFFF0000000000000, 0, 0, 1, 4'd7, "R7");
      send(64'h47EFFFFFF0000000, RN, 64'h7FF0000000000000, 0, 0, 1, 4'd6, "R7");
      send(64'h47EFFFFFF0000000, RZ, 64'h47EFFFFFE0000000, 0, 1, 0, 4'd4, "R7");
      // R8 tiny values
      send(64'h36A0000000000000, RN, 64'h36A0000000000000, 0, 0, 0, 4'd2, "R8");
      send(64'h37D8000000000000, RN, 64'h37D8000000000000, 0, 0, 0, 4'd2, "R8");
      send(64'h3690000000000000, RN, 64'h0000000000000000, 0, 1, 0, 4'd0, "R8");
      send(64'h3690000000000000, RU, 64'h36A0000000000000, 0, 1, 0, 4'd2, "R8");
      send(64'h3698000000000000, RN, 64'h36A0000000000000, 0, 1, 0, 4'd2, "R8");
      send(64'hB690000000000000, RD, 64'hB6A0000000000000, 0, 1, 0, 4'd3, "R8");
      send(64'h380FFFFFE0000000, RN, 64'h3810000000000000, 0, 1, 0, 4'd4, "R8");
      send(64'h380FFFFFE0000000, RZ, 64'h380FFFFFC0000000, 0, 1, 0, 4'd2, "R8");
      send(64'h0000000000000001, RZ, 64'h0000000000000000, 0, 1, 0, 4'd0, "R8");
      send(64'h0000000000000001, RU, 64'h36A0000000000000, 0, 1, 0, 4'd2, "R8");
      send(64'h8000000000000001, RD, 64'hB6A0000000000000, 0, 1, 0, 4'd3, "R8");
      // R10 operands with the strobe low are ignored; class holds
      idle(4, 64'h7FF0000000000001);
      send(64'hC000000000000000, RN, 64'hC000000000000000, 0, 0, 0, 4'd5, "R10");
      idle(4, 64'h7FE0000000000000);

      // R1 every request answered
      check(sb_q.size() == 0, "R1", "scoreboard drained", 64'(sb_q.size()), 64'd0);
      finish_run();
   end

endmodule